// File: doc/BRIEF.md
# Dual Tapped Shift Register with Segment Load

The block holds two independent 64-stage serial shift registers. Each register is cut into four 16-stage segments, and the last stage of every segment is brought out as a tap. In shift mode a rising clock edge moves the whole register by one place as a single 64-stage chain. Each tap then shows the bit that has just left its segment. The bit that leaves the last segment is lost.

In load mode the three inner taps become inputs. On each rising edge the first stage of the second, third and fourth segment takes its bit from the tap line in front of it, and stage 1 takes the serial input. All four segments fill at the same time, so a full 64-bit word enters in 16 clocks rather than 64. The taps are meant to sit on a shared bus. Each tap has a separate output-enable, and the block drops all of them while load mode is selected, so that outside drivers can use the inner tap lines.

Each channel has its own clock, serial input and mode input. A single active-low reset clears both channels at once. Each channel releases the reset in step with its own clock.

Top module: `dual_tapped_shreg`

## Requirements
- R1: While `rst_n` is low, every stage of both channels reads 0 at once, without waiting for a clock edge. After `rst_n` rises, each channel begins shifting on the third rising edge of its own clock.
- R2: On every rising edge of a channel clock, stage 1 of that channel takes the channel's serial input, in either mode.
- R3: With the mode input at 1 (load), a rising edge loads stages 17, 33 and 49 from `tap_in[0]`, `tap_in[1]` and `tap_in[2]`. Inside each segment the bits shift by one place.
- R4: With the mode input at 0 (shift), a rising edge moves the register as one chain: stage 17 takes stage 16, stage 33 takes stage 32, and stage 49 takes stage 48.
- R5: `tap_out[k]` always shows stage 16·(k+1). Sixteen load-mode edges place a complete 64-bit word, and a word with stage s equal to bit s-1 appears at once as `tap_out[k]` = bit 16k+15.
- R6: `tap_oe` follows the mode input combinationally: all four bits are 0 while the mode input is 1 and all four are 1 while it is 0.
- R7: A channel keeps its contents unchanged for as long as its clock does not rise, whatever its other inputs do.
- R8: The two channels are independent. Inputs and clock edges of one channel never change the taps of the other.
- R9: Data that leaves stage 64 is dropped. After 64 shift-mode edges with the serial input held at 0, all four taps read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both channels |
| a_clk | input | 1 | Channel A clock, rising edge active |
| a_din | input | 1 | Channel A serial input to stage 1 |
| a_wr | input | 1 | Channel A mode: 1 load, 0 shift |
| a_tap_in | input | 3 | Channel A inner tap inputs, entering stages 17, 33, 49 |
| a_tap_out | output | 4 | Channel A taps after stages 16, 32, 48, 64 |
| a_tap_oe | output | 4 | Channel A tap output enables |
| b_clk | input | 1 | Channel B clock, rising edge active |
| b_din | input | 1 | Channel B serial input to stage 1 |
| b_wr | input | 1 | Channel B mode: 1 load, 0 shift |
| b_tap_in | input | 3 | Channel B inner tap inputs, entering stages 17, 33, 49 |
| b_tap_out | output | 4 | Channel B taps after stages 16, 32, 48, 64 |
| b_tap_oe | output | 4 | Channel B tap output enables |

## Verification
The output enables are combinational and are due in the same cycle as the mode input. The bench checks them 1 ns after it changes the inputs, before the next edge. Every tap is one register from its source, so a tap value is due just after the rising edge that captured it. The bench samples 1 ns after each edge it drives and compares against a reference model that it has already advanced by that edge. Reset clearing is due with no edge at all and is sampled 1 ns after `rst_n` falls. The idle channel's taps are compared on every step of the active channel to show that its contents hold and that the channels do not interact.

// File: rtl/tsr_pkg.sv
`timescale 1ns/1ps
package tsr_pkg;
  typedef enum logic {
    MODE_SHIFT = 1'b0,
    MODE_LOAD  = 1'b1
  } tsr_mode_e;
endpackage

// File: rtl/tsr_reset_sync.sv
`timescale 1ns/1ps
module tsr_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q = sync_q[STAGES-1];
endmodule

// File: rtl/tsr_segment.sv
`timescale 1ns/1ps
module tsr_segment #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_in,
  output logic head,
  output logic tail
);
  logic [LEN-1:0] stg_q;
  logic [LEN-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[LEN-2:0], ser_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign head = stg_q[0];
  assign tail = stg_q[LEN-1];
endmodule

// File: rtl/tsr_channel.sv
`timescale 1ns/1ps
module tsr_channel
  import tsr_pkg::*;
#(
  parameter int SEG_LEN = 16,
  parameter int NUM_SEG = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               din,
  input  logic               wr,
  input  logic [NUM_SEG-2:0] tap_in,
  output logic [NUM_SEG-1:0] tap_out,
  output logic [NUM_SEG-1:0] tap_oe
);
  tsr_mode_e          mode;
  logic               rst_q;
  logic [NUM_SEG-1:0] seg_in;
  logic [NUM_SEG-1:0] head;
  logic [NUM_SEG-1:0] tail;

  assign mode = tsr_mode_e'(wr);

  tsr_reset_sync #(.STAGES(2)) u_rsync (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
    if (k == 0) begin : g_first
      assign seg_in[k] = din;
    end else begin : g_inner
      always_comb begin
        if (mode == MODE_LOAD) seg_in[k] = tap_in[k-1];
        else                   seg_in[k] = tail[k-1];
      end

      // R3
      load_path_chk: assert property (@(posedge clk) disable iff (!rst_q)
        ($past(rst_q) && $past(wr)) |-> (head[k] == $past(tap_in[k-1])));

      // R4
      chain_path_chk: assert property (@(posedge clk) disable iff (!rst_q)
        ($past(rst_q) && !$past(wr)) |-> (head[k] == $past(tail[k-1])));
    end

    tsr_segment #(.LEN(SEG_LEN)) u_seg (
      .clk    (clk),
      .rst_n  (rst_q),
      .ser_in (seg_in[k]),
      .head   (head[k]),
      .tail   (tail[k])
    );
  end

  assign tap_out = tail;
  assign tap_oe  = (mode == MODE_LOAD) ? '0 : '1;

  // R2
  head_capture_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $past(rst_q) |-> (head[0] == $past(din)));

  // R6
  always_comb begin
    if (rst_q) begin
      oe_uniform_chk: assert ((tap_oe == '0) || (tap_oe == '1));
    end
  end
endmodule

// File: rtl/dual_tapped_shreg.sv
`timescale 1ns/1ps
module dual_tapped_shreg #(
  parameter int SEG_LEN = 16,
  parameter int NUM_SEG = 4
) (
  input  logic               rst_n,
  input  logic               a_clk,
  input  logic               a_din,
  input  logic               a_wr,
  input  logic [NUM_SEG-2:0] a_tap_in,
  output logic [NUM_SEG-1:0] a_tap_out,
  output logic [NUM_SEG-1:0] a_tap_oe,
  input  logic               b_clk,
  input  logic               b_din,
  input  logic               b_wr,
  input  logic [NUM_SEG-2:0] b_tap_in,
  output logic [NUM_SEG-1:0] b_tap_out,
  output logic [NUM_SEG-1:0] b_tap_oe
);
  tsr_channel #(.SEG_LEN(SEG_LEN), .NUM_SEG(NUM_SEG)) u_cha (
    .clk     (a_clk),
    .rst_n   (rst_n),
    .din     (a_din),
    .wr      (a_wr),
    .tap_in  (a_tap_in),
    .tap_out (a_tap_out),
    .tap_oe  (a_tap_oe)
  );

  tsr_channel #(.SEG_LEN(SEG_LEN), .NUM_SEG(NUM_SEG)) u_chb (
    .clk     (b_clk),
    .rst_n   (rst_n),
    .din     (b_din),
    .wr      (b_wr),
    .tap_in  (b_tap_in),
    .tap_out (b_tap_out),
    .tap_oe  (b_tap_oe)
  );
endmodule

// File: tb/dual_tapped_shreg_test.sv
`timescale 1ns/1ps
module dual_tapped_shreg_test;
  localparam int SL = 16;
  localparam int NS = 4;
  localparam int TOT = SL * NS;

  logic          rst_n;
  logic          a_clk, a_din, a_wr, b_clk, b_din, b_wr;
  logic [NS-2:0] a_tin, b_tin;
  logic [NS-1:0] a_tout, a_oe, b_tout, b_oe;

  logic [TOT-1:0] ma, mb;
  int n_chk, n_fail;
  bit done;

  dual_tapped_shreg uut (
    .rst_n(rst_n),
    .a_clk(a_clk), .a_din(a_din), .a_wr(a_wr), .a_tap_in(a_tin),
    .a_tap_out(a_tout), .a_tap_oe(a_oe),
    .b_clk(b_clk), .b_din(b_din), .b_wr(b_wr), .b_tap_in(b_tin),
    .b_tap_out(b_tout), .b_tap_oe(b_oe)
  );

  function automatic logic [TOT-1:0] model_next(input logic [TOT-1:0] s,
      input logic d, input logic w, input logic [NS-2:0] t);
    logic [TOT-1:0] n;
    n = {s[TOT-2:0], d};
    if (w) for (int k = 1; k < NS; k++) n[k*SL] = t[k-1];
    return n;
  endfunction

  function automatic logic [NS-1:0] taps_of(input logic [TOT-1:0] s);
    logic [NS-1:0] r;
    for (int k = 0; k < NS; k++) r[k] = s[k*SL + SL - 1];
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one 5 ns clock period on channel A (ch=0) or B (ch=1)
  task automatic step(input int ch, input logic d, input logic w,
                      input logic [NS-2:0] t, input string req);
    if (ch == 0) begin a_din = d; a_wr = w; a_tin = t; end
    else         begin b_din = d; b_wr = w; b_tin = t; end
    #1;
    chk("R6", (ch == 0) ? a_oe : b_oe, {NS{~w}});
    #1.5;
    if (ch == 0) begin a_clk = 1; ma = model_next(ma, d, w, t); end
    else         begin b_clk = 1; mb = model_next(mb, d, w, t); end
    #1;
    if (ch == 0) begin
      chk(req, a_tout, taps_of(ma));
      chk("R7", b_tout, taps_of(mb));
    end else begin
      chk(req, b_tout, taps_of(mb));
      chk("R7", a_tout, taps_of(ma));
    end
    #1.5;
    if (ch == 0) a_clk = 0; else b_clk = 0;
  endtask

  task automatic both_pulse();
    #2.5 a_clk = 1; b_clk = 1;
    #2.5 a_clk = 0; b_clk = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; a_din = 0; a_wr = 0; a_tin = '0; b_din = 0; b_wr = 0; b_tin = '0;
    #1;
    chk("R1", {a_tout, b_tout}, '0);
    ma = '0; mb = '0;
    both_pulse();
    #1 rst_n = 1;
    for (int i = 0; i < 3; i++) both_pulse();
    chk("R1", {a_tout, b_tout}, '0);
  endtask

  // load word p: stage s ends up holding p[s-1]
  task automatic load_word(input int ch, input logic [TOT-1:0] p);
    for (int j = 0; j < SL; j++) begin
      logic [NS-2:0] t;
      for (int k = 1; k < NS; k++) t[k-1] = p[k*SL + SL - 1 - j];
      step(ch, p[SL-1-j], 1'b1, t, "R3");
    end
    for (int k = 0; k < NS; k++)
      chk("R5", (ch == 0) ? a_tout[k] : b_tout[k], p[k*SL + SL - 1]);
  endtask

  initial begin
    done = 0;
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [TOT-1:0] pat;
    n_chk = 0; n_fail = 0;
    a_clk = 0; b_clk = 0;
    void'($urandom(32'h5EED_0042));
    do_reset();

    // R2: single one enters stage 1 and reaches tap 16 after 16 edges
    step(0, 1'b1, 1'b0, '0, "R2");
    for (int i = 1; i < SL; i++) step(0, 1'b0, 1'b0, '0, "R2");
    chk("R2", a_tout, 4'b0001);

    // R5: parallel load on A, then serial unload through the chain
    pat = 64'hF0E1_D2C3_B4A5_9687;
    load_word(0, pat);
    for (int m = 1; m <= TOT; m++) begin
      step(0, 1'b0, 1'b0, '0, "R4");
      chk("R4", a_tout[NS-1], (m < TOT) ? pat[TOT-1-m] : 1'b0);
    end
    chk("R9", a_tout, '0);

    // R8: different words in both channels, each loaded while the other idles
    load_word(0, pat);
    load_word(1, ~pat);
    chk("R8", {a_tout, b_tout}, {taps_of(pat), taps_of(~pat)});

    // R7: inputs toggle on A with no clock edge
    a_din = 1; a_wr = 0; a_tin = 3'b101; #3; a_wr = 1; #3;
    chk("R7", a_tout, taps_of(pat));
    a_wr = 0;

    // R1: asynchronous clear with data present
    do_reset();

    // random mix on both channels
    for (int i = 0; i < 600; i++) begin
      logic w;
      int ch;
      ch = $urandom_range(0, 1);
      w  = ($urandom_range(0, 2) == 0);
      step(ch, 1'($urandom), w, (NS-1)'($urandom), w ? "R3" : "R4");
    end

    // R9 on B: flush with zeros
    for (int m = 0; m < TOT; m++) step(1, 1'b0, 1'b0, '0, "R4");
    chk("R9", b_tout, '0);

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule